// File: doc/BRIEF.md
# Floating-point compare flag generator

The block compares two IEEE-754 operands and turns the relation between them into a four-bit condition nibble and an invalid-operation flag. A format input selects single or double precision. In single precision only the low 32 bits of each operand are used. A mode input selects a quiet compare or a signalling compare. Zeros of either sign, infinities, denormals and NaNs are all handled.

The result is registered, so it appears one clock after the operands are presented. The nibble is packed as {N,Z,C,V}, with N in bit 3. Each relation has its own code, and there is a separate code for unordered. A downstream condition evaluator can therefore use the nibble directly as its flag state. The block does no arithmetic other than the comparison. It writes no status register and raises no trap.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When the operands are equal and neither is a NaN, flags_o = 4'b0110 (Z and C set).
- R2: When operand a is less than operand b, flags_o = 4'b1000 (N only).
- R3: When operand a is greater than operand b, flags_o = 4'b0010 (C only).
- R4: When either operand is a NaN (exponent all ones and fraction nonzero), flags_o = 4'b0011 (C and V).
- R5: Positive zero and negative zero compare as equal, in both formats.
- R6: Denormal operands are ordered exactly by value and are never flushed to zero.
- R7: With dbl_i = 0, the operands are a_i[31:0] and b_i[31:0] in single format (8-bit exponent, 23-bit fraction), and bits 63:32 have no effect. With dbl_i = 1, the full 64 bits are used in double format (11-bit exponent, 52-bit fraction).
- R8: With sig_i = 0 (quiet), invalid_o is 1 only when at least one operand is a signalling NaN, that is, a NaN whose fraction MSB is 0.
- R9: With sig_i = 1 (signalling), invalid_o is 1 whenever either operand is any NaN.
- R10: After reset, flags_o = 0 and invalid_o = 0. The operands sampled at a rising clock edge determine the outputs from that edge until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision on the low 32 bits |
| sig_i | input | 1 | 1 = signalling compare, 0 = quiet compare |
| flags_o | output | 4 | Condition nibble {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation exception |

## Verification
A wrong sign decision or a wrong magnitude decision inside the comparator shows up as swapped N and C codes, or as a lost Z code. It appears on flags_o in the very cycle after the offending operands are sampled. A faulty NaN classifier shows up as an unordered code on ordered inputs, or the reverse, and as an invalid_o pulse that disagrees with the mode. A format-select fault makes the upper operand bits leak into single-precision results, and the same-cycle code then differs from the expected one.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int SP_EXP = 8;
  localparam int SP_MAN = 23;
  localparam int DP_EXP = 11;
  localparam int DP_MAN = 52;
  localparam int SP_W   = 1 + SP_EXP + SP_MAN;
  localparam int DP_W   = 1 + DP_EXP + DP_MAN;

  // {N,Z,C,V}
  typedef enum logic [3:0] {
    FL_NONE = 4'b0000,
    FL_GT   = 4'b0010,
    FL_UN   = 4'b0011,
    FL_EQ   = 4'b0110,
    FL_LT   = 4'b1000
  } fl_code_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic lt;
    logic eq;
  } cmp_res_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [MAG_W:0]   op_i,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             zero_o,
  output logic             nan_o,
  output logic             snan_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;

  assign sign_o  = op_i[MAG_W];
  assign mag_o   = op_i[MAG_W-1:0];
  assign exp_f   = op_i[MAG_W-1:MAN_W];
  assign man_f   = op_i[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign zero_o  = ~|mag_o;
  assign nan_o   = exp_max & (|man_f);
  // fraction MSB clear marks a signalling NaN
  assign snan_o  = nan_o & ~man_f[MAN_W-1];
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int MAG_W = 31
) (
  input  logic             sa_i,
  input  logic [MAG_W-1:0] ma_i,
  input  logic             za_i,
  input  logic             sb_i,
  input  logic [MAG_W-1:0] mb_i,
  input  logic             zb_i,
  output logic             lt_o,
  output logic             eq_o
);
  logic mag_lt, mag_gt, both_zero;

  assign mag_lt    = ma_i < mb_i;
  assign mag_gt    = ma_i > mb_i;
  assign both_zero = za_i & zb_i;

  always_comb begin
    eq_o = both_zero | ((sa_i == sb_i) & (ma_i == mb_i));
    if (both_zero)        lt_o = 1'b0;
    else if (sa_i != sb_i) lt_o = sa_i;
    else if (sa_i)         lt_o = mag_gt;
    else                   lt_o = mag_lt;
  end
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [MAG_W:0] a_i,
  input  logic [MAG_W:0] b_i,
  output cmp_res_t       res_o
);
  logic [MAG_W:0]   ops   [2];
  logic             sgn   [2];
  logic [MAG_W-1:0] mag   [2];
  logic             zro   [2];
  logic             nan   [2];
  logic             snan  [2];
  logic             lt, eq;

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i   (ops[i]),
      .sign_o (sgn[i]),
      .mag_o  (mag[i]),
      .zero_o (zro[i]),
      .nan_o  (nan[i]),
      .snan_o (snan[i])
    );
  end

  fcmp_order #(.MAG_W(MAG_W)) u_ord (
    .sa_i (sgn[0]), .ma_i (mag[0]), .za_i (zro[0]),
    .sb_i (sgn[1]), .mb_i (mag[1]), .zb_i (zro[1]),
    .lt_o (lt),
    .eq_o (eq)
  );

  assign res_o.nan  = nan[0] | nan[1];
  assign res_o.snan = snan[0] | snan[1];
  assign res_o.lt   = lt;
  assign res_o.eq   = eq;
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DP_W-1:0] a_i,
  input  logic [DP_W-1:0] b_i,
  input  logic            dbl_i,
  input  logic            sig_i,
  output logic [3:0]      flags_o,
  output logic            invalid_o
);
  cmp_res_t  sp_res, dp_res, sel;
  fl_code_e  code_d;
  logic      inv_d;
  logic [3:0] flags_q;
  logic       inv_q;

  fcmp_lane #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
    .a_i   (a_i[SP_W-1:0]),
    .b_i   (b_i[SP_W-1:0]),
    .res_o (sp_res)
  );

  fcmp_lane #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (dp_res)
  );

  always_comb begin
    sel = dbl_i ? dp_res : sp_res;
    if (sel.nan)     code_d = FL_UN;
    else if (sel.eq) code_d = FL_EQ;
    else if (sel.lt) code_d = FL_LT;
    else             code_d = FL_GT;
    inv_d = sig_i ? sel.nan : sel.snan;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= FL_NONE;
      inv_q   <= 1'b0;
    end else begin
      flags_q <= code_d;
      inv_q   <= inv_d;
    end
  end

  assign flags_o   = flags_q;
  assign invalid_o = inv_q;
endmodule

// File: rtl/fcmp_flag_chk.sv
module fcmp_flag_chk
  import fcmp_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [DP_W-1:0] a_i,
  input logic [DP_W-1:0] b_i,
  input logic            dbl_i,
  input logic            sig_i,
  input logic [3:0]      flags_o,
  input logic            invalid_o
);
  logic [DP_W-1:0] a_q, b_q;
  logic            dbl_q, sig_q, seen_q;
  logic            a_nan, b_nan, a_zero, b_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; dbl_q <= 1'b0; sig_q <= 1'b0; seen_q <= 1'b0;
    end else begin
      a_q <= a_i; b_q <= b_i; dbl_q <= dbl_i; sig_q <= sig_i; seen_q <= 1'b1;
    end
  end

  always_comb begin
    if (dbl_q) begin
      a_nan  = (&a_q[62:52]) & (|a_q[51:0]);
      b_nan  = (&b_q[62:52]) & (|b_q[51:0]);
      a_zero = ~|a_q[62:0];
      b_zero = ~|b_q[62:0];
    end else begin
      a_nan  = (&a_q[30:23]) & (|a_q[22:0]);
      b_nan  = (&b_q[30:23]) & (|b_q[22:0]);
      a_zero = ~|a_q[30:0];
      b_zero = ~|b_q[30:0];
    end
  end

  // R1
  flags_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (flags_o == FL_EQ || flags_o == FL_LT || flags_o == FL_GT || flags_o == FL_UN));

  // R1
  self_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && a_q == b_q && !a_nan) |-> flags_o == FL_EQ);

  // R4
  nan_unord_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && (a_nan || b_nan)) |-> flags_o == FL_UN);

  // R5
  zero_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && a_zero && b_zero) |-> flags_o == FL_EQ);

  // R8
  inv_needs_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> flags_o == FL_UN);

  // R9
  sig_nan_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && sig_q && flags_o == FL_UN) |-> invalid_o);
endmodule

bind fcmp_flag_unit fcmp_flag_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_i       (a_i),
  .b_i       (b_i),
  .dbl_i     (dbl_i),
  .sig_i     (sig_i),
  .flags_o   (flags_o),
  .invalid_o (invalid_o)
);

// File: tb/sim_fcmp_flag_unit.sv
module sim_fcmp_flag_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        dbl_i = 1'b0, sig_i = 1'b0;
  logic [3:0]  flags_o;
  logic        invalid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  fcmp_flag_unit u0 (.*);

  function automatic logic [63:0] sp_val(int i);
    case (i)
      0: return 64'h00000000;  1: return 64'h80000000;
      2: return 64'h00000001;  3: return 64'h80000001;
      4: return 64'h007fffff;  5: return 64'h00800000;
      6: return 64'h3f800000;  7: return 64'hbf800000;
      8: return 64'h40000000;  9: return 64'h7f7fffff;
      10: return 64'h7f800000; 11: return 64'hff800000;
      12: return 64'h7fc00000; 13: return 64'h7f800001;
      14: return 64'hffc00001; default: return 64'h00000002;
    endcase
  endfunction

  function automatic logic [63:0] dp_val(int i);
    case (i)
      0: return 64'h0;                  1: return 64'h8000000000000000;
      2: return 64'h1;                  3: return 64'h8000000000000001;
      4: return 64'h000fffffffffffff;   5: return 64'h0010000000000000;
      6: return 64'h3ff0000000000000;   7: return 64'hbff0000000000000;
      8: return 64'h4000000000000000;   9: return 64'h7fefffffffffffff;
      10: return 64'h7ff0000000000000;  11: return 64'hfff0000000000000;
      12: return 64'h7ff8000000000000;  13: return 64'h7ff0000000000001;
      14: return 64'hfff8000000000001;  default: return 64'h2;
    endcase
  endfunction

  // Normalise to a 64-bit sign-magnitude value
  function automatic logic [63:0] widen(logic [63:0] v, logic d);
    return d ? v : {v[31], v[30:0], 32'h0};
  endfunction

  function automatic bit is_nan(logic [63:0] w);
    return (&w[62:52]) ? (|w[51:0]) : 1'b0;
  endfunction

  function automatic bit is_snan_raw(logic [63:0] v, logic d);
    if (d) return (&v[62:52]) && (|v[51:0]) && !v[51];
    return (&v[30:23]) && (|v[22:0]) && !v[22];
  endfunction

  function automatic bit is_nan_raw(logic [63:0] v, logic d);
    if (d) return (&v[62:52]) && (|v[51:0]);
    return (&v[30:23]) && (|v[22:0]);
  endfunction

  function automatic logic [63:0] okey(logic [63:0] w);
    logic [63:0] z;
    z = (w[62:0] == 63'h0) ? 64'h0 : w;
    return z[63] ? ~z : (z ^ 64'h8000000000000000);
  endfunction

  function automatic bit is_den(logic [63:0] v, logic d);
    if (d) return v[62:52] == 0 && v[51:0] != 0;
    return v[30:23] == 0 && v[22:0] != 0;
  endfunction

  task automatic check(input logic [63:0] a, b, input logic d, s, input string tag);
    logic [3:0] ef; logic ei; logic [63:0] ka, kb; string ftag;
    bit un;
    un = is_nan_raw(a, d) || is_nan_raw(b, d);
    ka = okey(widen(a, d)); kb = okey(widen(b, d));
    if (un) begin ef = 4'b0011; ftag = "R4"; end
    else if (ka == kb) begin ef = 4'b0110; ftag = "R1"; end
    else if (ka < kb) begin ef = 4'b1000; ftag = "R2"; end
    else begin ef = 4'b0010; ftag = "R3"; end
    if (!un && a[62:0] == 0 && b[62:0] == 0 && d) ftag = "R5";
    if (!un && a[30:0] == 0 && b[30:0] == 0 && !d) ftag = "R5";
    if (!un && (is_den(a, d) || is_den(b, d))) ftag = "R6";
    ei = un && (s || is_snan_raw(a, d) || is_snan_raw(b, d));
    a_i = a; b_i = b; dbl_i = d; sig_i = s;
    @(posedge clk_i); @(negedge clk_i);
    n_chk++;
    if (flags_o !== ef) begin
      n_fail++;
      $display("FAIL %s %s a=%h b=%h dbl=%0b: flags %b expected %b", ftag, tag, a, b, d, flags_o, ef);
    end
    n_chk++;
    if (invalid_o !== ei) begin
      n_fail++;
      $display("FAIL %s %s a=%h b=%h dbl=%0b: invalid %b expected %b",
               s ? "R9" : "R8", tag, a, b, d, invalid_o, ei);
    end
  endtask

  initial begin
    logic [63:0] lf, a, b;
    lf = 64'hace1_2468_1357_bdf9;
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (flags_o !== 4'b0000 || invalid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: flags %b inv %b expected 0000 0", flags_o, invalid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep all special pairs, both formats and modes
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++) begin
            if (d == 1) check(dp_val(i), dp_val(j), 1'b1, s[0], "dp");
            else check({32'hfff80000, sp_val(i)[31:0]}, {32'h7ff00001, sp_val(j)[31:0]},
                       1'b0, s[0], "sp R7");
          end

    // R7: upper bits differ, low single values equal
    check({32'h00000000, 32'h3f800000}, {32'h7ff80000, 32'h3f800000}, 1'b0, 1'b1, "R7");

    // random pairs, nearby magnitudes to exercise ordering
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      a = lf;
      b = (k % 3 == 0) ? (lf ^ 64'h1) : {lf[31:0], lf[63:32]};
      if (k % 5 == 0) b = {a[63:1], ~a[0]} ^ 64'h8000000000000000;
      check(a, b, k[0], k[1], "rand");
    end

    // R10: output holds until the next edge after the new operands
    a_i = 64'h3ff0000000000000; b_i = 64'h4000000000000000; dbl_i = 1'b1; sig_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    a_i = 64'h4000000000000000; b_i = 64'h3ff0000000000000;
    #5;
    n_chk++;
    if (flags_o !== 4'b1000) begin
      n_fail++;
      $display("FAIL R10 latency: flags %b expected 1000", flags_o);
    end
    @(posedge clk_i); @(negedge clk_i);
    n_chk++;
    if (flags_o !== 4'b0010) begin
      n_fail++;
      $display("FAIL R10 update: flags %b expected 0010", flags_o);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule